// File: doc/BRIEF.md
# Delayed Transmit/Receive Switch Driver

This block drives the control line of an external antenna transmit/receive switch. A transmit request exists whenever the transmit sample FIFO holds data. Samples leave the interpolator and the DAC some time after they leave that FIFO. If the switch followed the FIFO flag directly, it would move tens of microseconds too early on both edges and cut off the end of a burst. To prevent this, the block waits a programmable number of clock ticks after the request appears before it turns the switch to transmit. It waits a second, independent number of ticks after the request goes away before it turns the switch back to receive.

Each delay is 16 bits wide. This covers the transmit pipeline latency, which grows as roughly fifty ticks plus three ticks per unit of interpolation ratio. A single counter times whichever edge is pending. Software can turn automatic switching off. The line then follows a static manual level.

Top module: `atr_switch_delay`

## Requirements
- R1: While reset is asserted and on release, `switch_out` is 0.
- R2: With `atr_en` = 0, `switch_out` equals the `manual_level` sampled at the previous clock edge, whatever the FIFO does.
- R3: The transmit request is the inverse of `tx_fifo_empty` (request active when `tx_fifo_empty` = 0).
- R4: With `atr_en` = 1 and `switch_out` = 0, let the first rising clock edge that samples an active request be edge k. Then `switch_out` becomes 1 at edge k + `rise_delay`, provided the request stays active.
- R5: With `atr_en` = 1 and `switch_out` = 1, let the first edge that samples an inactive request be edge k. Then `switch_out` becomes 0 at edge k + `fall_delay`, provided the request stays inactive.
- R6: A delay value of 0 makes the corresponding transition at the first edge that samples the new request level.
- R7: If the request returns to the current output level before a pending delay expires, no transition happens. The next request change times its full delay again from zero.
- R8: Rising transitions use only `rise_delay` and falling transitions use only `fall_delay`.
- R9: When `atr_en` goes from 0 to 1 while the output differs from the request, timing starts from zero at the first enabled edge, with the delay for that direction.
- R10: If the delay for a pending edge is lowered to a value at or below the ticks already counted, the transition happens at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_fifo_empty | input | 1 | Transmit FIFO empty flag |
| atr_en | input | 1 | Automatic switching enable |
| manual_level | input | 1 | Switch level while automatic switching is off |
| rise_delay | input | 16 | Ticks from request start to transmit position |
| fall_delay | input | 16 | Ticks from request end to receive position |
| switch_out | output | 1 | Registered switch control (1 = transmit) |

## Verification
The bench sweeps every pair of rise and fall delays from 0 to 6. Before and after the expected edge it checks the output on each cycle, which exposes an off-by-one counter, as well as a design that swaps the two delay registers or ignores the zero-delay case. It also aborts a pending rise halfway. A design that kept its count would then switch early on the next request, and one that did not cancel would switch with no request present. It also covers:
- Lowering a delay mid-count. A design using an equality compare would hang instead of switching on the next edge.
- Leaving manual mode at a level opposite the request. A design that did not restart timing there would switch at once or never.

// File: rtl/atr_pkg.sv
package atr_pkg;
  parameter int unsigned DELAY_W = 16;
  typedef logic [DELAY_W-1:0] delay_t;
endpackage

// File: rtl/atr_delay_select.sv
module atr_delay_select #(
  parameter int unsigned DW = 16
) (
  input  logic          to_tx,
  input  logic [DW-1:0] rise_delay,
  input  logic [DW-1:0] fall_delay,
  output logic [DW-1:0] limit
);
  // pending edge direction chooses its own delay register
  always_comb begin
    if (to_tx) limit = rise_delay;
    else       limit = fall_delay;
  end
endmodule

// File: rtl/atr_delay_timer.sv
module atr_delay_timer #(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [DW-1:0] limit,
  output logic          expired
);
  logic [DW-1:0] count_q, count_d;
  logic          count_en;

  assign expired  = (count_q >= limit);
  assign count_en = 1'b1;

  always_comb begin
    if (clr || expired) count_d = '0;
    else                count_d = count_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= '0;
    else if (count_en) count_q <= count_d;
  end

  // R7: a cleared timer restarts from zero
  assert_clear_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count_q == '0));
endmodule

// File: rtl/atr_switch_delay.sv
module atr_switch_delay
  import atr_pkg::*;
#(
  parameter int unsigned DW = DELAY_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_fifo_empty,
  input  logic          atr_en,
  input  logic          manual_level,
  input  logic [DW-1:0] rise_delay,
  input  logic [DW-1:0] fall_delay,
  output logic          switch_out
);
  logic          req;
  logic          sw_q, sw_d;
  logic          busy;
  logic          expired;
  logic [DW-1:0] limit;

  assign req  = ~tx_fifo_empty;
  assign busy = atr_en && (req != sw_q);

  atr_delay_select #(.DW(DW)) i_select (
    .to_tx      (req),
    .rise_delay (rise_delay),
    .fall_delay (fall_delay),
    .limit      (limit)
  );

  atr_delay_timer #(.DW(DW)) i_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (!busy),
    .limit   (limit),
    .expired (expired)
  );

  always_comb begin
    sw_d = sw_q;
    if (!atr_en)              sw_d = manual_level;
    else if (busy && expired) sw_d = req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sw_q <= 1'b0;
    else        sw_q <= sw_d;
  end

  assign switch_out = sw_q;

  assert_manual_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !atr_en |=> (switch_out == $past(manual_level)));

  assert_rise_needs_request_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (atr_en && tx_fifo_empty && !switch_out) |=> !switch_out);

  assert_zero_delay_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && limit == '0) |=> (switch_out == $past(req)));

  assert_no_move_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (atr_en && (req == switch_out)) |=> $stable(switch_out));
endmodule

// File: tb/test_atr_switch_delay.sv
module test_atr_switch_delay;
  localparam int DW = 16;
  logic clk, rst_n, tx_fifo_empty, atr_en, manual_level;
  logic [DW-1:0] rise_delay, fall_delay;
  logic switch_out;
  int checks, failures;

  atr_switch_delay #(.DW(DW)) i_atr_switch_delay (
    .clk(clk), .rst_n(rst_n), .tx_fifo_empty(tx_fifo_empty), .atr_en(atr_en),
    .manual_level(manual_level), .rise_delay(rise_delay), .fall_delay(fall_delay),
    .switch_out(switch_out));

  initial clk = 0;
  always #2.5 clk = ~clk;

  task automatic check(input logic exp, input string req);
    checks++;
    if (switch_out !== exp) begin
      failures++;
      $display("FAIL %s: switch_out=%b expected=%b at %0t", req, switch_out, exp, $time);
    end
  endtask

  task automatic nc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // drive request level at a negedge, then check each cycle; transition after edge k+d
  task automatic edge_test(input logic to_tx, input int d, input string req);
    tx_fifo_empty = ~to_tx;
    for (int i = 1; i <= d + 1; i++) begin
      @(negedge clk);
      check((i >= d + 1) ? to_tx : ~to_tx, req);
    end
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checks = 0; failures = 0;
    rst_n = 0; tx_fifo_empty = 0; atr_en = 1; manual_level = 1;
    rise_delay = 0; fall_delay = 0;
    nc(3);
    check(1'b0, "R1 in reset");
    rst_n = 1; tx_fifo_empty = 1;
    @(negedge clk);
    check(1'b0, "R1 after release");

    // R2 manual mode, FIFO busy but ignored
    atr_en = 0; tx_fifo_empty = 0;
    for (int i = 0; i < 6; i++) begin
      manual_level = i[0];
      @(negedge clk);
      check(i[0], "R2 manual follow");
    end
    manual_level = 0; tx_fifo_empty = 1; nc(1);
    atr_en = 1; nc(2);

    // R3 R4 R5 R6 R8 sweep
    for (int r = 0; r <= 6; r++) begin
      for (int f = 0; f <= 6; f++) begin
        rise_delay = DW'(r); fall_delay = DW'(f);
        edge_test(1'b1, r, (r == 0) ? "R6 R4 R3 R8 rise" : "R4 R3 R8 rise");
        nc(2); check(1'b1, "R4 hold");
        edge_test(1'b0, f, (f == 0) ? "R6 R5 R8 fall" : "R5 R8 fall");
        nc(2); check(1'b0, "R5 hold");
      end
    end

    // R7 cancel then restart
    rise_delay = 5; fall_delay = 2;
    tx_fifo_empty = 0; nc(3);
    check(1'b0, "R7 pending");
    tx_fifo_empty = 1;
    for (int i = 0; i < 10; i++) begin @(negedge clk); check(1'b0, "R7 cancelled"); end
    edge_test(1'b1, 5, "R7 restart full rise");
    // cancel a pending fall
    tx_fifo_empty = 1; nc(1);
    tx_fifo_empty = 0;
    for (int i = 0; i < 6; i++) begin @(negedge clk); check(1'b1, "R7 fall cancelled"); end
    edge_test(1'b0, 2, "R7 restart full fall");

    // R10 lower delay mid-count
    rise_delay = 10;
    tx_fifo_empty = 0; nc(4);
    check(1'b0, "R10 before shrink");
    rise_delay = 2;
    @(negedge clk);
    check(1'b1, "R10 shrink fires next edge");
    tx_fifo_empty = 1; fall_delay = 0; nc(2);

    // R9 enable from manual at opposite level
    atr_en = 0; manual_level = 1; nc(2);
    check(1'b1, "R9 manual high");
    fall_delay = 3; atr_en = 1;
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk);
      check((i >= 4) ? 1'b0 : 1'b1, "R9 timed from enable");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule